// File: doc/BRIEF.md
# Column-Ordered Bitmap Scanout with Colour Lookup

This block turns a 4-bit-per-pixel bitmap held in an external dual-port video RAM into a stream of 24-bit RGB pixels. The bitmap is stored column by column. The low address byte selects the scanline and the upper address bits select a byte column. Each byte carries two horizontally adjacent pixels: the high nibble is the left pixel and the low nibble is the right pixel. An external raster generator supplies horizontal and vertical counters. The block issues the matching RAM read address, splits the returned byte into two colour indices, and resolves each index through a bank of sixteen writable colour registers.

Each colour register holds an 8-bit packed code. Blue takes the top two bits, green the middle three and red the bottom three. Every field is widened to 8 bits through fixed per-bit weights. Only a band of scanlines is shown. Rows outside that band are flagged as blanked and produce black. Columns past the visible width of a shown row produce black with the valid flag low. The CPU writes the colour registers through a simple write strobe with an index and a code.

Top module: `colpix_scanout`

## Requirements
- R1: `vram_addr` equals `{hcount[8:1], vcount[7:0]}` in the same cycle, so that both pixels of a byte column share one read address.
- R2: The video RAM returns data one clock after it sees an address. The pixel outputs for the counters presented in clock n are registered at the end of clock n+1, which is two clock edges after the counters are sampled.
- R3: An even pixel (hcount[0]=0) takes its colour index from bits [7:4] of the byte returned for its column. The following odd pixel takes bits [3:0] of that same byte.
- R4: There are sixteen colour registers. When `pal_we` is high, `pal_code` is stored into the register selected by `pal_idx`. Lookups made from the next clock onward see the new code. A lookup of the same index in the write cycle sees the old code.
- R5: A code expands with red from bits [2:0], green from bits [5:3] and blue from bits [7:6]. A 3-bit field becomes bit0*33 + bit1*71 + bit2*151. The 2-bit blue field becomes bit0*71 + bit1*151. `pix_rgb` is {red, green, blue} in bits [23:16], [15:8] and [7:0].
- R6: For scanlines below 6 or above 245, `row_blank` is 1, `pix_valid` is 0 and `pix_rgb` is 0. For scanlines 6 to 245, `row_blank` is 0.
- R7: In a shown row, pixels with hcount of 304 or more give `pix_valid` 0 and `pix_rgb` 0. Pixels 0 to 303 give `pix_valid` 1 and the looked-up colour.
- R8: Synchronous active-low reset clears all colour registers to 0 and drives `pix_valid` 0, `pix_rgb` 0 and `row_blank` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hcount | input | 9 | Horizontal raster position (pixel x) |
| vcount | input | 8 | Vertical raster position (scanline) |
| vram_addr | output | 16 | Read address to the video RAM |
| vram_data | input | 8 | Byte returned by the video RAM one clock after the address |
| pal_we | input | 1 | Colour register write strobe |
| pal_idx | input | 4 | Colour register being written |
| pal_code | input | 8 | Packed colour code to store |
| pix_rgb | output | 24 | Pixel colour, red in the top byte |
| pix_valid | output | 1 | Pixel lies inside the shown area |
| row_blank | output | 1 | Current output row is outside the shown band |

## Verification
The read address is combinational, so the bench compares it one time step after driving the counters. Every pixel result is due two clock edges after its counters are driven. The bench therefore pushes the expected colour, valid flag and blank flag into a two-deep queue when it drives the counters, and compares them two falling edges later. The expected colour comes from a model palette. That model takes each write before it computes the pixel driven in the same cycle, which matches the rule that a write is seen one clock after it is issued.

// File: rtl/colpix_pkg.sv
// Package: shared constants and colour-expansion helpers for the scanout.
// Assumes an 8-bit packed code: blue [7:6], green [5:3], red [2:0].
package colpix_pkg;

    // Per-bit weights that widen a colour field to 8 bits
    localparam int unsigned W_LO  = 33;
    localparam int unsigned W_MID = 71;
    localparam int unsigned W_HI  = 151;

    // 24-bit output pixel
    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    // Widen a 3-bit field with the three weights (sum is 255)
    function automatic logic [7:0] widen3(input logic [2:0] f);
        int unsigned acc;
        acc = (f[0] ? W_LO : 0) + (f[1] ? W_MID : 0) + (f[2] ? W_HI : 0);
        return acc[7:0];
    endfunction

    // Widen a 2-bit field with the two upper weights (sum is 222)
    function automatic logic [7:0] widen2(input logic [1:0] f);
        int unsigned acc;
        acc = (f[0] ? W_MID : 0) + (f[1] ? W_HI : 0);
        return acc[7:0];
    endfunction

endpackage

// File: rtl/colpix_fetch.sv
// Module: colpix_fetch
// Forms the column-ordered RAM read address from the raster counters and
// selects the colour index nibble from the returned byte.
// Assumes the RAM answers one clock after it sees the address, and that an
// odd pixel always follows the even pixel of the same byte column.
module colpix_fetch #(
    parameter int XW        = 9,
    parameter int YW        = 8,
    parameter int PIXW      = 4,
    parameter int H_SHOWN   = 304,
    parameter int ROW_FIRST = 6,
    parameter int ROW_LAST  = 245,
    localparam int ADDR_W   = XW - 1 + YW,
    localparam int BYTE_W   = 2 * PIXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     hcount,
    input  logic [YW-1:0]     vcount,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [BYTE_W-1:0] vram_data,
    output logic [PIXW-1:0]   pix_idx,
    output logic              row_ok_q,
    output logic              col_ok_q
);

    logic            odd_q;
    logic [PIXW-1:0] held_lo;
    logic            row_ok_d;
    logic            col_ok_d;

    // Column index in the high bits, scanline in the low byte
    assign vram_addr = {hcount[XW-1:1], vcount};

    // Decide whether the sampled position lies in the shown area
    always_comb begin
        row_ok_d = (vcount >= YW'(ROW_FIRST)) && (vcount <= YW'(ROW_LAST));
        col_ok_d = (hcount < XW'(H_SHOWN));
    end

    // Carry pixel parity and position flags alongside the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q    <= 1'b0;
            row_ok_q <= 1'b0;
            col_ok_q <= 1'b0;
        end else begin
            odd_q    <= hcount[0];
            row_ok_q <= row_ok_d;
            col_ok_q <= col_ok_d;
        end
    end

    // Keep the right-hand nibble of an even byte for the odd pixel after it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_lo <= '0;
        end else if (!odd_q) begin
            held_lo <= vram_data[PIXW-1:0];
        end
    end

    // Left pixel uses the upper nibble; right pixel uses the held nibble
    always_comb begin
        pix_idx = odd_q ? held_lo : vram_data[BYTE_W-1:PIXW];
    end

endmodule

// File: rtl/colpix_palette.sv
// Module: colpix_palette
// Bank of writable colour registers with one asynchronous read port.
// Assumes one write per clock; a read of the index being written returns the
// stored (old) code because the register updates at the clock edge.
module colpix_palette #(
    parameter int IDXW  = 4,
    parameter int CODEW = 8,
    localparam int NREG = 1 << IDXW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [CODEW-1:0] wr_code,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [CODEW-1:0] rd_code
);

    logic [CODEW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Store a new code into register i when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_idx == IDXW'(i))) begin
                regs[i] <= wr_code;
            end
        end
    end

    // Select the code for the current pixel index
    always_comb begin
        rd_code = regs[rd_idx];
    end

endmodule

// File: rtl/colpix_expand.sv
// Module: colpix_expand
// Widens a packed blue/green/red code to 24-bit RGB with fixed bit weights.
// Purely combinational; assumes the 8-bit layout defined in colpix_pkg.
module colpix_expand
    import colpix_pkg::*;
(
    input  logic [7:0] code,
    output rgb_t       rgb
);

    // Split the code into fields and widen each to a full byte
    always_comb begin
        rgb.red   = widen3(code[2:0]);
        rgb.green = widen3(code[5:3]);
        rgb.blue  = widen2(code[7:6]);
    end

endmodule

// File: rtl/colpix_scanout.sv
// Module: colpix_scanout (top)
// Column-ordered bitmap scanout: address generation, nibble selection,
// colour register lookup and a registered RGB output with valid and blank.
// Assumes a synchronous-read video RAM with one clock of latency and raster
// counters that step one pixel per clock within a row.
module colpix_scanout #(
    parameter int XW        = 9,
    parameter int YW        = 8,
    parameter int IDXW      = 4,
    parameter int H_SHOWN   = 304,
    parameter int ROW_FIRST = 6,
    parameter int ROW_LAST  = 245,
    localparam int ADDR_W   = XW - 1 + YW,
    localparam int BYTE_W   = 2 * IDXW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     hcount,
    input  logic [YW-1:0]     vcount,
    output logic [ADDR_W-1:0] vram_addr,
    input  logic [BYTE_W-1:0] vram_data,
    input  logic              pal_we,
    input  logic [IDXW-1:0]   pal_idx,
    input  logic [7:0]        pal_code,
    output logic [23:0]       pix_rgb,
    output logic              pix_valid,
    output logic              row_blank
);
    import colpix_pkg::*;

    logic [IDXW-1:0] idx_s1;
    logic            row_ok_s1;
    logic            col_ok_s1;
    logic [7:0]      code_s1;
    rgb_t            rgb_s1;

    colpix_fetch #(
        .XW        (XW),
        .YW        (YW),
        .PIXW      (IDXW),
        .H_SHOWN   (H_SHOWN),
        .ROW_FIRST (ROW_FIRST),
        .ROW_LAST  (ROW_LAST)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcount    (hcount),
        .vcount    (vcount),
        .vram_addr (vram_addr),
        .vram_data (vram_data),
        .pix_idx   (idx_s1),
        .row_ok_q  (row_ok_s1),
        .col_ok_q  (col_ok_s1)
    );

    colpix_palette #(
        .IDXW  (IDXW),
        .CODEW (8)
    ) u_pal (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_we),
        .wr_idx  (pal_idx),
        .wr_code (pal_code),
        .rd_idx  (idx_s1),
        .rd_code (code_s1)
    );

    colpix_expand u_expand (
        .code (code_s1),
        .rgb  (rgb_s1)
    );

    // Register the final pixel, forcing black outside the shown area
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rgb   <= '0;
            pix_valid <= 1'b0;
            row_blank <= 1'b1;
        end else begin
            row_blank <= !row_ok_s1;
            pix_valid <= row_ok_s1 && col_ok_s1;
            pix_rgb   <= (row_ok_s1 && col_ok_s1) ? rgb_s1 : '0;
        end
    end

endmodule

// File: rtl/colpix_scanout_chk.sv
// Module: colpix_scanout_chk
// Property checker for colpix_scanout, attached with a bind below.
// Assumes the counters are sampled at the same edges as the design.
module colpix_scanout_chk #(
    parameter int XW        = 9,
    parameter int YW        = 8,
    parameter int ROW_FIRST = 6,
    parameter int ROW_LAST  = 245,
    localparam int ADDR_W   = XW - 1 + YW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XW-1:0]     hcount,
    input logic [YW-1:0]     vcount,
    input logic [ADDR_W-1:0] vram_addr,
    input logic [23:0]       pix_rgb,
    input logic              pix_valid,
    input logic              row_blank
);

    logic [1:0] age;

    // Count clocks since reset, saturating, to guard $past lookups
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R6: a blanked row never carries a valid or coloured pixel
    a_r6_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        row_blank |-> (!pix_valid && pix_rgb == 24'd0));

    // R7: a valid pixel only appears in a shown row
    a_r7_valid_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !row_blank);

    // R2/R6: the blank flag follows the scanline two edges after it is sampled
    a_r2_row_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(vcount, 2) >= YW'(ROW_FIRST) && $past(vcount, 2) <= YW'(ROW_LAST))
        |-> !row_blank);

    a_r2_row_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && ($past(vcount, 2) < YW'(ROW_FIRST) || $past(vcount, 2) > YW'(ROW_LAST)))
        |-> row_blank);

    // R1: an odd pixel directly after its even partner reuses the read address
    a_r1_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd1 && hcount[0] && ($past(hcount) + 1'b1 == hcount) && $past(vcount) == vcount)
        |-> vram_addr == $past(vram_addr));

    // R8: the first outputs after reset are the cleared state
    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd1) |-> (row_blank && !pix_valid && pix_rgb == 24'd0));

endmodule

bind colpix_scanout colpix_scanout_chk #(
    .XW        (XW),
    .YW        (YW),
    .ROW_FIRST (ROW_FIRST),
    .ROW_LAST  (ROW_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hcount    (hcount),
    .vcount    (vcount),
    .vram_addr (vram_addr),
    .pix_rgb   (pix_rgb),
    .pix_valid (pix_valid),
    .row_blank (row_blank)
);

// File: tb/colpix_scanout_test.sv
// Bench for colpix_scanout: sweeps whole frames row by row, reprograms the
// colour registers at chosen points and compares every pixel with an
// arithmetic model two edges after the counters are driven.
module colpix_scanout_test;

    localparam int H_TOTAL = 312;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  hcount = '0;
    logic [7:0]  vcount = '0;
    logic [15:0] vram_addr;
    logic [7:0]  vram_data = '0;
    logic        pal_we = 1'b0;
    logic [3:0]  pal_idx = '0;
    logic [7:0]  pal_code = '0;
    logic [23:0] pix_rgb;
    logic        pix_valid;
    logic        row_blank;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0]  model_pal [16];
    logic [23:0] q_rgb [2];
    logic        q_val [2];
    logic        q_blk [2];
    int          fill = 0;
    int          wcnt = 0;

    always #10 clk = ~clk;

    colpix_scanout uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcount    (hcount),
        .vcount    (vcount),
        .vram_addr (vram_addr),
        .vram_data (vram_data),
        .pal_we    (pal_we),
        .pal_idx   (pal_idx),
        .pal_code  (pal_code),
        .pix_rgb   (pix_rgb),
        .pix_valid (pix_valid),
        .row_blank (row_blank)
    );

    // Bitmap content as a function of the address
    function automatic logic [7:0] ram_f(input logic [15:0] a);
        return (a[15:8] * 8'd29) ^ (a[7:0] * 8'd53) ^ {a[2:0], a[12:8]};
    endfunction

    // Synchronous-read RAM model with one clock of latency
    always @(posedge clk) vram_data <= ram_f(vram_addr);

    function automatic logic [7:0] w3(input logic [2:0] f);
        return 8'(f[0] * 33 + f[1] * 71 + f[2] * 151);
    endfunction

    function automatic logic [7:0] w2(input logic [1:0] f);
        return 8'(f[0] * 71 + f[1] * 151);
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s x=%0d y=%0d actual=%h expected=%h", req, hcount, vcount, act, exp);
        end
    endtask

    // One pixel clock: check due outputs, drive new inputs, queue expectation
    task automatic step(input int x, input int y, input bit we, input int idx, input int code);
        logic [15:0] a;
        logic [7:0]  b;
        logic [3:0]  nib;
        logic [7:0]  c;
        bit          row_ok, col_ok;
        @(negedge clk);
        if (fill >= 2) begin
            check("R6 row_blank", {23'd0, row_blank}, {23'd0, q_blk[0]});
            check("R7 pix_valid", {23'd0, pix_valid}, {23'd0, q_val[0]});
            check("R2/R3/R4/R5 pix_rgb", pix_rgb, q_rgb[0]);
        end
        hcount   = 9'(x);
        vcount   = 8'(y);
        pal_we   = we;
        pal_idx  = 4'(idx);
        pal_code = 8'(code);
        if (we) model_pal[idx] = 8'(code);
        a = {hcount[8:1], vcount};
        b = ram_f(a);
        nib = hcount[0] ? b[3:0] : b[7:4];
        c = model_pal[nib];
        row_ok = (y >= 6) && (y <= 245);
        col_ok = (x < 304);
        q_rgb[0] = q_rgb[1];
        q_val[0] = q_val[1];
        q_blk[0] = q_blk[1];
        q_rgb[1] = (row_ok && col_ok) ? {w3(c[2:0]), w3(c[5:3]), w2(c[7:6])} : 24'd0;
        q_val[1] = row_ok && col_ok;
        q_blk[1] = !row_ok;
        fill++;
        #1;
        check("R1 vram_addr", {8'd0, vram_addr}, {8'd0, a});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #4000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_pal[i] = 8'd0;
        // R8: reset state while reset is held
        repeat (3) @(negedge clk);
        check("R8 reset pix_rgb", pix_rgb, 24'd0);
        check("R8 reset pix_valid", {23'd0, pix_valid}, 24'd0);
        check("R8 reset row_blank", {23'd0, row_blank}, 24'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // Frame 1: palette starts cleared (R8), loaded at the start of row 6,
        // rewritten every third pixel on rows 100 and 101 (R4)
        for (int y = 0; y < 256; y++) begin
            for (int x = 0; x < H_TOTAL; x++) begin
                if (y == 6 && x < 16)
                    step(x, y, 1'b1, x, (x * 37 + 11) & 255);
                else if ((y == 100 || y == 101) && (x % 3 == 0))
                    step(x, y, 1'b1, (x / 3) & 15, (x * 13 + y) & 255);
                else
                    step(x, y, 1'b0, 0, 0);
            end
        end

        // Frame 2: every code value written while the same entries are read,
        // including same-cycle write and lookup of one index (R4, R5)
        for (int y = 0; y < 256; y++) begin
            for (int x = 0; x < H_TOTAL; x++) begin
                if (y >= 40 && y < 80) begin
                    step(x, y, 1'b1, wcnt & 15, (wcnt * 7) & 255);
                    wcnt++;
                end else begin
                    step(x, y, 1'b0, 0, 0);
                end
            end
        end

        // Drain the last two queued pixels
        step(0, 0, 1'b0, 0, 0);
        step(0, 0, 1'b0, 0, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule